// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits. It turns each single-word read or write request into a timed sequence on the memory's active-low chip enable, write enable, output enable and two byte strobes. The minimum nanosecond timings are parameters. Each is converted to a whole number of clock cycles by ceiling division by the clock period, with at least one cycle per phase.

The host raises `req` with `wr`, `addr`, `wdata` and `be` while `ready` is high. The controller registers the request, runs the access and pulses `ack` for one cycle when it is done. For a read, `rdata` is valid in that same cycle.

On the memory side the data bus is split into an output, an output enable and an input, for a pad or tristate stage outside this block. The controller holds write enable high whenever the address moves. After the memory's output enable is released, it waits a turnaround interval before it drives the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `ready` is 1, `ack` is 0, `mem_dq_oe` is 0, and `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1.
- R2: A request is taken only in a cycle where `ready` is 1. A `req` raised while `ready` is 0 leaves the memory contents, the address and the count of `ack` pulses unchanged.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, where RD_CYC is ceil(max(read cycle, address access)/period) and equals 14 at 70 ns and 5 ns. `mem_dq_in` is sampled at the clock edge that ends the last of these cycles, and `rdata` holds it during the single `ack` cycle.
- R4: Byte lanes are ordered: bits 7:0 are the lower lane, with strobe `mem_lb_n` low when `be[0]`=1. Bits 15:8 are the upper lane, with strobe `mem_ub_n` low when `be[1]`=1. Both strobes are high while `mem_ce_n` is high. A lane not requested in a read returns 0 in `rdata`, and a lane not requested in a write is left unchanged in memory.
- R5: A write holds `mem_we_n`=0 for exactly WP_CYC cycles, where WP_CYC is ceil(max(write pulse, data setup)/period) and equals 7 by default. During those cycles `mem_ce_n`=0, `mem_oe_n`=1 and the write data is driven.
- R6: `mem_addr` changes only in a cycle where `mem_we_n` is 1 both in that cycle and in the cycle before.
- R7: For a write, `mem_ce_n` stays low for at least ceil(write cycle/period) cycles (14 by default). This includes at least one setup cycle before `mem_we_n` falls and at least one recovery cycle after it rises.
- R8: `mem_dq_oe` is 1 only while `mem_oe_n` has been high for at least TA_CYC = ceil(turnaround/period) cycles (6 by default). It drops in the same cycle that `mem_we_n` rises, and it is never 1 while the memory is enabled to drive.
- R9: Every accepted request yields exactly one `ack` pulse one cycle long. `ready` is 0 from the cycle after acceptance until the `ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Host request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| ready | output | 1 | Controller can take a request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The assertions check several rules on every cycle. Read and write control combinations must never overlap. Strobes stay idle while the chip is deselected. The address moves only with write enable high. The data drive waits out the turnaround and drops as write enable rises. `ack` is a single-cycle pulse, and the address holds while the controller is busy.

Other behaviours only the bench scenarios can show, against a cycle-accurate memory model that returns junk before the access window closes and on unstrobed lanes. These are the exact pulse and window lengths, the sampling cycle of read data and the zeroing of unrequested lanes. They also include the effect of byte-masked writes on stored contents and the fact that requests made while busy are ignored.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPL  = 3'd3,
    ST_WRC  = 3'd4
  } asram_st_e;

  // ceiling division of a time by the clock period, never below one cycle
  function automatic int ns2cyc(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
`timescale 1ns/1ps
module asram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/asram_ta_timer.sv
`timescale 1ns/1ps
module asram_ta_timer #(
  parameter int W    = 4,
  parameter int LOAD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = W'(LOAD);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
module asram_lanes #(
  parameter int LANES = 2
) (
  input  logic                 ce_n,
  input  logic [LANES-1:0]     be_q,
  input  logic [8*LANES-1:0]   din,
  output logic [LANES-1:0]     strb_n,
  output logic [8*LANES-1:0]   dmask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strb_n[i]       = ce_n | ~be_q[i];
    assign dmask[8*i +: 8] = be_q[i] ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 35,
  parameter int T_DW_NS = 30,
  parameter int T_AS_NS = 0,
  parameter int T_WR_NS = 0,
  parameter int T_TA_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        be,
  output logic              ready,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = ns2cyc(imax(T_RC_NS, T_AA_NS), CLK_NS);
  localparam int AS_CYC = ns2cyc(T_AS_NS, CLK_NS);
  localparam int WP_CYC = ns2cyc(imax(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int WC_CYC = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WR_CYC = imax(ns2cyc(T_WR_NS, CLK_NS), WC_CYC - AS_CYC - WP_CYC);
  localparam int TA_CYC = ns2cyc(T_TA_NS, CLK_NS);
  localparam int MAX_C  = imax(imax(RD_CYC, WP_CYC), imax(imax(AS_CYC, WR_CYC), TA_CYC));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic              rst_q_n;
  asram_st_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q, rd_masked;
  logic [LANES-1:0]  be_q, strb_n;
  logic              ack_q;
  logic              take, smp, fin, ta_zero;

  asram_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q_n(rst_q_n)
  );

  asram_ta_timer #(.W(CNT_W), .LOAD(TA_CYC)) u_ta (
    .clk  (clk),
    .rst_n(rst_q_n),
    .load (smp),
    .zero (ta_zero)
  );

  asram_lanes #(.LANES(LANES)) u_lanes (
    .ce_n  (mem_ce_n),
    .be_q  (be_q),
    .din   (mem_dq_in),
    .strb_n(strb_n),
    .dmask (rd_masked)
  );

  assign take = (st_q == ST_IDLE) && req;

  // next-state and phase counter
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    smp   = 1'b0;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req) st_d = wr ? ST_WSU : ST_RD;
      end
      ST_RD: begin
        if (cnt_q == CNT_W'(RD_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          smp   = 1'b1;
        end
      end
      ST_WSU: begin
        if (cnt_q >= CNT_W'(AS_CYC - 1)) begin
          cnt_d = cnt_q;
          if (ta_zero) begin
            st_d  = ST_WPL;
            cnt_d = '0;
          end
        end
      end
      ST_WPL: begin
        if (cnt_q == CNT_W'(WP_CYC - 1)) begin
          st_d  = ST_WRC;
          cnt_d = '0;
        end
      end
      ST_WRC: begin
        if (cnt_q == CNT_W'(WR_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          fin   = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ack_q <= smp | fin;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      be_q   <= '0;
    end else if (take) begin
      addr_q <= addr;
      wdat_q <= wdata;
      be_q   <= be;
    end
  end

  // read capture, enabled on the last access cycle
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  rdat_q <= '0;
    else if (smp)  rdat_q <= rd_masked;
  end

  assign ready      = (st_q == ST_IDLE);
  assign ack        = ack_q;
  assign rdata      = rdat_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = (st_q == ST_IDLE);
  assign mem_oe_n   = (st_q != ST_RD);
  assign mem_we_n   = (st_q != ST_WPL);
  assign mem_dq_oe  = (st_q == ST_WPL);
  assign mem_dq_out = wdat_q;
  assign mem_lb_n   = strb_n[0];
  assign mem_ub_n   = strb_n[LANES-1];
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int TA_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  localparam int AW = $clog2(TA_CYC + 2);
  logic [AW-1:0] oe_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      oe_age <= AW'(TA_CYC);
    else if (!mem_oe_n)              oe_age <= '0;
    else if (oe_age != AW'(TA_CYC))  oe_age <= oe_age + 1'b1;
  end

  // R3
  rd_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R5
  wr_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R4
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (oe_age >= AW'(TA_CYC)));

  // R8
  drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .TA_CYC(TA_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .ready    (ready),
  .ack      (ack),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_lb_n (mem_lb_n),
  .mem_ub_n (mem_ub_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  localparam int PER_NS = 5;
  localparam int RD_CYC = (70 + PER_NS - 1) / PER_NS;
  localparam int WP_CYC = (35 + PER_NS - 1) / PER_NS;
  localparam int WC_CYC = (70 + PER_NS - 1) / PER_NS;
  localparam int TA_CYC = (30 + PER_NS - 1) / PER_NS;

  logic        clk, rst_n, req, wr;
  logic [17:0] addr;
  logic [15:0] wdata;
  logic [1:0]  be;
  logic        ready, ack;
  logic [15:0] rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  asram_ctrl #(.CLK_NS(PER_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .ready(ready), .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_bad, n_req, n_acks;

  task automatic chk(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] sram [logic [17:0]];
  logic [15:0] mdl_wr, mdl_rd;
  int          rd_age;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
    else                                    rd_age <= 0;
    if (!mem_ce_n && !mem_we_n) begin
      mdl_wr = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0;
      if (!mem_lb_n) mdl_wr[7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
      if (!mem_ub_n) mdl_wr[15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
      sram[mem_addr] = mdl_wr;
    end
  end

  always @* begin
    mdl_rd    = 16'h0;
    mem_dq_in = 16'h5A5A;
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RD_CYC - 1) begin
      mdl_rd    = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0;
      mem_dq_in = {mem_ub_n ? 8'hA5 : mdl_rd[15:8], mem_lb_n ? 8'hA5 : mdl_rd[7:0]};
    end
  end

  // ---------------- bus observers ----------------
  int          we_run, ce_run, last_wp, last_ce, oe_hi, last_gap, viol6, viol8;
  logic        prev_we, prev_dqoe;
  logic [17:0] prev_addr;

  always @(negedge clk) begin
    if (!rst_n) begin
      we_run = 0; ce_run = 0; oe_hi = 1000; viol6 = 0; viol8 = 0;
      prev_we = 1'b1; prev_dqoe = 1'b0; prev_addr = mem_addr;
    end else begin
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin last_wp = we_run; we_run = 0; end
      if (!mem_ce_n) ce_run++;
      else if (ce_run != 0) begin last_ce = ce_run; ce_run = 0; end
      if (mem_dq_oe && !prev_dqoe) last_gap = oe_hi;
      if (mem_oe_n) oe_hi++; else oe_hi = 0;
      if (mem_addr !== prev_addr && !(mem_we_n && prev_we)) viol6++;
      if (mem_dq_oe && (mem_we_n || !mem_oe_n)) viol8++;
      prev_we = mem_we_n; prev_dqoe = mem_dq_oe; prev_addr = mem_addr;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          is_wr;
    logic [15:0] exp;
    logic [31:0] tag;
  } sb_t;
  sb_t         sb_q[$];
  logic [15:0] ref_mem [logic [17:0]];

  task automatic access(input bit w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] b, input logic [31:0] tag);
    sb_t         it;
    logic [15:0] cur;
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; be = b;
    cur = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
    it.is_wr = w;
    it.tag   = tag;
    if (w) begin
      if (b[0]) cur[7:0]  = d[7:0];
      if (b[1]) cur[15:8] = d[15:8];
      ref_mem[a] = cur;
      it.exp = 16'h0;
    end else begin
      it.exp = {b[1] ? cur[15:8] : 8'h00, b[0] ? cur[7:0] : 8'h00};
    end
    sb_q.push_back(it);
    n_req++;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    sb_t it;
    if (rst_n && ack) begin
      n_acks++;
      if (sb_q.size() == 0) chk("R9", 32'd1, 32'd0);
      else begin
        it = sb_q.pop_front();
        if (!it.is_wr) chk(it.tag, {16'h0, rdata}, {16'h0, it.exp});
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; n_req = 0; n_acks = 0; rd_age = 0;
    last_wp = 0; last_ce = 0; last_gap = 0;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; be = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", ready, 1);
    chk("R1", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    chk("R1", {ack, mem_dq_oe}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 6'h3F);

    // R5 / R7: full-word writes
    access(1'b1, 18'h00010, 16'h1234, 2'b11, "R5");
    wait_idle();
    chk("R5", last_wp, WP_CYC);
    chk("R7", last_ce >= WC_CYC, 1);
    access(1'b1, 18'h3FFFF, 16'hABCD, 2'b11, "R5");
    access(1'b1, 18'h00000, 16'hFFFF, 2'b11, "R5");

    // R3: reads back at low, high and middle addresses
    access(1'b0, 18'h00010, 16'h0, 2'b11, "R3");
    access(1'b0, 18'h3FFFF, 16'h0, 2'b11, "R3");
    access(1'b0, 18'h00000, 16'h0, 2'b11, "R3");
    wait_idle();
    chk("R3", last_ce, RD_CYC);

    // R4: byte-lane writes and partial reads
    access(1'b1, 18'h00010, 16'h5566, 2'b01, "R4");
    access(1'b1, 18'h3FFFF, 16'h7788, 2'b10, "R4");
    access(1'b0, 18'h00010, 16'h0, 2'b11, "R4");
    access(1'b0, 18'h3FFFF, 16'h0, 2'b11, "R4");
    access(1'b0, 18'h3FFFF, 16'h0, 2'b01, "R4");
    access(1'b0, 18'h3FFFF, 16'h0, 2'b10, "R4");
    access(1'b0, 18'h3FFFF, 16'h0, 2'b00, "R4");

    // R8: read followed at once by a write needs the turnaround gap
    access(1'b0, 18'h00010, 16'h0, 2'b11, "R8");
    access(1'b1, 18'h00010, 16'hCAFE, 2'b11, "R8");
    wait_idle();
    chk("R8", last_gap >= TA_CYC, 1);
    access(1'b0, 18'h00010, 16'h0, 2'b11, "R8");

    // R2: a request while busy is ignored
    access(1'b1, 18'h00020, 16'h1111, 2'b11, "R2");
    chk("R9", ready, 0);
    req = 1'b1; wr = 1'b1; addr = 18'h00030; wdata = 16'h9999; be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    access(1'b0, 18'h00030, 16'h0, 2'b11, "R2");
    access(1'b0, 18'h00020, 16'h0, 2'b11, "R2");
    wait_idle();

    chk("R9", n_acks, n_req);
    chk("R6", viol6, 0);
    chk("R8", viol8, 0);
    report();
    $finish;
  end
endmodule